// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a virtual address into a physical address through a table of four segment descriptors. The two most significant bits of the virtual address pick a descriptor; the remaining bits form an offset into that segment. Each descriptor carries a base, a bound, a valid flag and three permission bits: fetch, load and store. A lookup adds the base to the offset and compares the offset against the bound. It returns one cycle later, either as a physical address or as a fault with a two-bit cause.

Descriptors leave reset holding a fixed configuration. They can be rewritten only while the kernel-mode input is high. A write attempted in user mode leaves the table unchanged and raises a one-cycle denial flag. A parameter collapses the table to a single segment that spans the whole virtual address. This gives plain base-and-bounds relocation.

Top module: `seg_xlate`

## Requirements
- R1: With SINGLE_SEG=0, virtual address bits [VA_W-1:VA_W-2] select the descriptor and bits [VA_W-3:0] are the offset. With SINGLE_SEG=1, descriptor 0 is always used and the whole virtual address is the offset.
- R2: An accepted request with no fault returns rspValid=1, rspFault=0, rspCause=00 and rspAddr = base + offset on the clock edge after acceptance.
- R3: An offset greater than or equal to the descriptor bound faults with cause 10. An offset equal to the bound faults.
- R4: An access to a descriptor whose valid flag is clear faults with cause 01. This cause outranks bound and permission faults.
- R5: Permission bit 0 allows fetch (reqType 00), bit 1 allows load (01) and bit 2 allows store (10). reqType 11 is never allowed. A disallowed access faults with cause 11. A bound fault outranks a permission fault.
- R6: After reset the descriptors hold the following values. Descriptor 0: base 0x4000, bound 0x700, fetch+load, valid. Descriptor 1: base 0x0, bound 0x500, fetch+load+store, valid. Descriptor 2: invalid. Descriptor 3: base 0x2000, bound 0x1000, fetch+load+store, valid.
- R7: cfgWrEn with kernelMode=1 loads base, bound, permission and valid into descriptor cfgIdx at the clock edge. The next request sees the new values, and cfgDenied stays 0.
- R8: cfgWrEn with kernelMode=0 leaves every descriptor unchanged and drives cfgDenied high for exactly the cycle after the attempt.
- R9: reqReady is low in any cycle where cfgWrEn is high, and a request in that cycle is not accepted. Each accepted request produces exactly one rspValid pulse, so back-to-back requests give back-to-back responses.
- R10: A faulting response has rspFault=1, a nonzero rspCause and rspAddr=0. The cause encoding is 00 none, 01 invalid, 10 out of bounds, 11 protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| kernelMode | input | 1 | High when the issuer of a descriptor write is privileged |
| cfgWrEn | input | 1 | Descriptor write strobe |
| cfgIdx | input | 2 | Descriptor to write |
| cfgBase | input | PA_W | New base |
| cfgBound | input | OFF_W+1 | New bound (exclusive limit) |
| cfgPerm | input | 3 | New permissions {store, load, fetch} |
| cfgValid | input | 1 | New valid flag |
| cfgDenied | output | 1 | Pulses the cycle after a user-mode write attempt |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqAddr | input | VA_W | Virtual address |
| reqType | input | 2 | Access type: 00 fetch, 01 load, 10 store, 11 reserved |
| rspValid | output | 1 | Result present |
| rspAddr | output | PA_W | Physical address, zero on a fault |
| rspFault | output | 1 | Result is a fault |
| rspCause | output | 2 | Fault cause |

## Verification
The bench builds two copies of the block. The first uses the default 16-bit virtual and physical addresses with SINGLE_SEG=0. In that build all four reset descriptors can be reached, and their offsets of 0x500, 0x700 and 0x1000 fit the 14-bit offset, so every bound edge can be hit exactly. The second copy uses SINGLE_SEG=1. There the top address bits become offset bits, which shows that they no longer steer the descriptor choice and that large addresses run past the single bound.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int NUM_SEG = 4;
  localparam int SEG_W   = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INVALID = 2'b01,
    CAUSE_BOUNDS  = 2'b10,
    CAUSE_PERM    = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } access_e;

  // strobes from control to datapath
  typedef struct packed {
    logic descWr;
    logic lookup;
  } strobes_t;

  // power-on descriptor contents (R6)
  function automatic logic [31:0] initBase(input int idx);
    case (idx)
      0:       return 32'h4000;
      3:       return 32'h2000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] initBound(input int idx);
    case (idx)
      0:       return 32'h700;
      1:       return 32'h500;
      3:       return 32'h1000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [2:0] initPerm(input int idx);
    case (idx)
      0:       return 3'b011;
      1, 3:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic initValid(input int idx);
    return idx != 2;
  endfunction

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     kernelMode,
  input  logic     cfgWrEn,
  input  logic     reqValid,
  output logic     reqReady,
  output logic     cfgDenied,
  output strobes_t strobes
);

  // a descriptor write owns the cycle; lookups wait
  assign reqReady       = !cfgWrEn;
  assign strobes.descWr = cfgWrEn && kernelMode;
  assign strobes.lookup = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgDenied <= 1'b0;
    else       cfgDenied <= cfgWrEn && !kernelMode;
  end

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 16,
  parameter bit SINGLE_SEG = 1'b0,
  localparam int OFF_W     = SINGLE_SEG ? VA_W : VA_W - SEG_W,
  localparam int BND_W     = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [SEG_W-1:0] cfgIdx,
  input  logic [PA_W-1:0]  cfgBase,
  input  logic [BND_W-1:0] cfgBound,
  input  logic [2:0]       cfgPerm,
  input  logic             cfgValid,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [1:0]       reqType,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspAddr,
  output logic             rspFault,
  output logic [1:0]       rspCause
);

  logic [PA_W-1:0]  baseQ  [NUM_SEG];
  logic [BND_W-1:0] boundQ [NUM_SEG];
  logic [2:0]       permQ  [NUM_SEG];
  logic             validQ [NUM_SEG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        baseQ[i]  <= PA_W'(initBase(i));
        boundQ[i] <= BND_W'(initBound(i));
        permQ[i]  <= initPerm(i);
        validQ[i] <= initValid(i);
      end
    end else if (strobes.descWr) begin
      baseQ[cfgIdx]  <= cfgBase;
      boundQ[cfgIdx] <= cfgBound;
      permQ[cfgIdx]  <= cfgPerm;
      validQ[cfgIdx] <= cfgValid;
    end
  end

  logic [SEG_W-1:0] segIdx;
  logic [OFF_W-1:0] offset;

  generate
    if (SINGLE_SEG) begin : g_flat
      assign segIdx = '0;
      assign offset = reqAddr;
    end else begin : g_seg
      assign segIdx = reqAddr[VA_W-1 -: SEG_W];
      assign offset = reqAddr[OFF_W-1:0];
    end
  endgenerate

  logic    permOk;
  logic    inBounds;
  cause_e  cause;
  logic [PA_W-1:0] physAddr;

  always_comb begin
    case (access_e'(reqType))
      ACC_FETCH: permOk = permQ[segIdx][0];
      ACC_LOAD:  permOk = permQ[segIdx][1];
      ACC_STORE: permOk = permQ[segIdx][2];
      default:   permOk = 1'b0;
    endcase
    inBounds = {1'b0, offset} < boundQ[segIdx];
    physAddr = baseQ[segIdx] + PA_W'(offset);
    if (!validQ[segIdx])  cause = CAUSE_INVALID;
    else if (!inBounds)   cause = CAUSE_BOUNDS;
    else if (!permOk)     cause = CAUSE_PERM;
    else                  cause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspFault <= 1'b0;
      rspCause <= CAUSE_NONE;
    end else begin
      rspValid <= strobes.lookup;
      if (strobes.lookup) begin
        rspFault <= cause != CAUSE_NONE;
        rspCause <= cause;
        rspAddr  <= (cause == CAUSE_NONE) ? physAddr : '0;
      end
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 16,
  parameter bit SINGLE_SEG = 1'b0,
  localparam int OFF_W     = SINGLE_SEG ? VA_W : VA_W - SEG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kernelMode,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgIdx,
  input  logic [PA_W-1:0]  cfgBase,
  input  logic [OFF_W:0]   cfgBound,
  input  logic [2:0]       cfgPerm,
  input  logic             cfgValid,
  output logic             cfgDenied,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [1:0]       reqType,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspAddr,
  output logic             rspFault,
  output logic [1:0]       rspCause
);

  strobes_t strobes;

  seg_xlate_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .kernelMode (kernelMode),
    .cfgWrEn    (cfgWrEn),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .cfgDenied  (cfgDenied),
    .strobes    (strobes)
  );

  seg_xlate_dp #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .SINGLE_SEG (SINGLE_SEG)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgIdx   (cfgIdx),
    .cfgBase  (cfgBase),
    .cfgBound (cfgBound),
    .cfgPerm  (cfgPerm),
    .cfgValid (cfgValid),
    .reqAddr  (reqAddr),
    .reqType  (reqType),
    .rspValid (rspValid),
    .rspAddr  (rspAddr),
    .rspFault (rspFault),
    .rspCause (rspCause)
  );

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            kernelMode,
  input logic            cfgWrEn,
  input logic            cfgDenied,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic [PA_W-1:0] rspAddr,
  input logic            rspFault,
  input logic [1:0]      rspCause
);

  assert_accept_gives_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  assert_rsp_needs_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));

  assert_write_blocks_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |-> !reqReady);

  assert_user_write_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !kernelMode) |=> cfgDenied);

  assert_kernel_write_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && kernelMode) |=> !cfgDenied);

  assert_fault_has_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault == (rspCause != 2'b00)));

  assert_fault_zero_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspAddr == '0));

endmodule

bind seg_xlate seg_xlate_checker #(.PA_W(PA_W)) i_chk (.*);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  localparam int VA_W = 16;
  localparam int PA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kernelMode = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgIdx = '0;
  logic [PA_W-1:0] cfgBase = '0;
  logic [14:0] cfgBound = '0;
  logic [2:0] cfgPerm = '0;
  logic cfgValid = 1'b0;
  logic cfgDenied;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [VA_W-1:0] reqAddr = '0;
  logic [1:0] reqType = '0;
  logic rspValid;
  logic [PA_W-1:0] rspAddr;
  logic rspFault;
  logic [1:0] rspCause;

  // flat (single-segment) copy
  logic [16:0] fBound = '0;
  logic fDenied, fReady, fValid, fFault;
  logic [PA_W-1:0] fAddr;
  logic [1:0] fCause;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_xlate #(.VA_W(VA_W), .PA_W(PA_W), .SINGLE_SEG(1'b0)) i_seg_xlate (
    .clk(clk), .rstN(rstN), .kernelMode(kernelMode), .cfgWrEn(cfgWrEn),
    .cfgIdx(cfgIdx), .cfgBase(cfgBase), .cfgBound(cfgBound), .cfgPerm(cfgPerm),
    .cfgValid(cfgValid), .cfgDenied(cfgDenied), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqType(reqType),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault), .rspCause(rspCause)
  );

  seg_xlate #(.VA_W(VA_W), .PA_W(PA_W), .SINGLE_SEG(1'b1)) i_seg_xlate_flat (
    .clk(clk), .rstN(rstN), .kernelMode(1'b1), .cfgWrEn(1'b0),
    .cfgIdx(2'b00), .cfgBase(16'h0), .cfgBound(fBound), .cfgPerm(3'b000),
    .cfgValid(1'b0), .cfgDenied(fDenied), .reqValid(reqValid),
    .reqReady(fReady), .reqAddr(reqAddr), .reqType(reqType),
    .rspValid(fValid), .rspAddr(fAddr), .rspFault(fFault), .rspCause(fCause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // response = {valid, fault, cause, addr}
  task automatic request(input logic [15:0] a, input logic [1:0] t);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    reqType  = t;
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic [1:0]  acc;
    logic [1:0]  cause;
    logic [15:0] pa;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 2'b00, 2'b00, 16'h4010},  // R1 R2 seg0 fetch
    '{16'h06FF, 2'b01, 2'b00, 16'h46FF},  // R3 last legal offset
    '{16'h0700, 2'b00, 2'b10, 16'h0000},  // R3 offset == bound
    '{16'h0010, 2'b10, 2'b11, 16'h0000},  // R5 store to code seg
    '{16'h44FF, 2'b10, 2'b00, 16'h04FF},  // R6 seg1 store
    '{16'h4500, 2'b01, 2'b10, 16'h0000},  // R3 seg1 bound
    '{16'h8000, 2'b01, 2'b01, 16'h0000},  // R4 seg2 invalid
    '{16'hBFFF, 2'b10, 2'b01, 16'h0000},  // R4 invalid outranks others
    '{16'hCFFF, 2'b10, 2'b00, 16'h2FFF},  // R6 seg3 top
    '{16'hD000, 2'b01, 2'b10, 16'h0000},  // R3 seg3 bound
    '{16'h0800, 2'b10, 2'b10, 16'h0000},  // R5 bounds outranks perm
    '{16'h4000, 2'b11, 2'b11, 16'h0000}   // R5 reserved type
  };

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #35;
    // reset state
    chk("R9 reset reqReady", 32'(reqReady), 32'd1);
    chk("R10 reset rspValid", 32'(rspValid), 32'd0);
    chk("R8 reset cfgDenied", 32'(cfgDenied), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // vector walk, back-to-back requests
    for (int i = 0; i < NV; i++) begin
      request(VECS[i].addr, VECS[i].acc);
      chk($sformatf("R9 vec%0d valid", i), 32'(rspValid), 32'd1);
      chk($sformatf("R10 vec%0d fault", i), 32'(rspFault), 32'(VECS[i].cause != 2'b00));
      chk($sformatf("R2 R10 vec%0d cause", i), 32'(rspCause), 32'(VECS[i].cause));
      chk($sformatf("R2 vec%0d addr", i), 32'(rspAddr), 32'(VECS[i].pa));
    end
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk); #1;
    chk("R9 idle no rspValid", 32'(rspValid), 32'd0);

    // user-mode write with a colliding request
    @(negedge clk);
    kernelMode = 1'b0; cfgWrEn = 1'b1; cfgIdx = 2'd2;
    cfgBase = 16'h1000; cfgBound = 15'h100; cfgPerm = 3'b010; cfgValid = 1'b1;
    reqValid = 1'b1; reqAddr = 16'h0010; reqType = 2'b00;
    #1;
    chk("R9 reqReady low on write", 32'(reqReady), 32'd0);
    @(posedge clk); #1;
    chk("R9 blocked request", 32'(rspValid), 32'd0);
    chk("R8 denied pulse", 32'(cfgDenied), 32'd1);
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0; kernelMode = 1'b1;
    @(posedge clk); #1;
    chk("R8 denied one cycle", 32'(cfgDenied), 32'd0);
    request(16'h80FF, 2'b01);
    chk("R8 seg2 still invalid", 32'(rspCause), 32'd1);

    // kernel write
    @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b1; kernelMode = 1'b1;
    @(posedge clk); #1;
    chk("R7 no denial", 32'(cfgDenied), 32'd0);
    @(negedge clk);
    cfgWrEn = 1'b0;
    request(16'h80FF, 2'b01);
    chk("R7 new base", 32'(rspAddr), 32'h10FF);
    chk("R7 new seg ok", 32'(rspCause), 32'd0);
    request(16'h8100, 2'b01);
    chk("R7 R3 new bound", 32'(rspCause), 32'd2);
    request(16'h8000, 2'b10);
    chk("R7 R5 new perm", 32'(rspCause), 32'd3);
    request(16'h8000, 2'b00);
    chk("R5 fetch denied", 32'(rspCause), 32'd3);

    // flat copy: whole address is offset into descriptor 0
    request(16'h06FF, 2'b00);
    chk("R1 flat addr", 32'(fAddr), 32'h46FF);
    chk("R1 flat ok", 32'(fCause), 32'd0);
    request(16'h4000, 2'b01);
    chk("R1 flat high bits are offset", 32'(fCause), 32'd2);
    @(negedge clk);
    reqValid = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule